// File: doc/BRIEF.md
# Serial Flash Power-Mode Controller

This block sits inside a serial-flash slave and keeps track of the device power state. It listens to the serial command bus (chip select active low, serial clock, serial data in), assembles the opcode and any bytes that follow it most-significant bit first, and acts on the command only when chip select returns high. Three states exist: ordinary standby, high-performance standby (charge pumps held pre-charged) and deep power-down.

All three bus inputs are brought into the system clock domain through a synchroniser, so the bus clock must run well below the system clock. Entering high-performance standby takes a settling time, given as a number of system clock cycles; a busy output covers that window. A one-cycle pulse marks every update of the mode output.

Top module: `flash_pwr_ctrl`

## Requirements
- R1: After reset, `pwr_mode` is 00 (standby), `busy` is 0 and `mode_changed` is 0. The mode code is 00 standby, 01 high-performance, 10 deep power-down, and 11 never appears.
- R2: In standby, a frame made of opcode A3h and exactly three dummy bytes (32 bus clocks in all) raises `busy` for exactly `HPM_CYCLES` system clocks. `pwr_mode` becomes 01 in the cycle after `busy` falls.
- R3: An A3h frame whose length is anything other than 32 bus clocks is discarded. An A3h frame received while already in high-performance standby is discarded too. The mode does not change in either case.
- R4: Opcode ABh (8 or more bus clocks) in high-performance standby returns the mode to 00. In standby it has no effect.
- R5: Opcode B9h (8 or more bus clocks) in high-performance standby moves the mode straight to 10.
- R6: Opcode B9h in standby moves the mode to 10.
- R7: In deep power-down, only opcode ABh has an effect, and it moves the mode to 00. A3h, B9h and any other opcode leave the mode at 10.
- R8: A frame with fewer than 8 bus clocks, or one with an opcode other than A3h, ABh or B9h, changes nothing.
- R9: A frame that completes while `busy` is high is ignored. While `busy` is high, the mode stays 00.
- R10: `mode_changed` is high for exactly the one system clock in which `pwr_mode` takes a new value, and is low at all other times.
- R11: Data bits are taken on rising bus clock edges only while chip select is low. The bit count restarts at each falling edge of chip select. The command is acted on 4 system clocks after chip select rises, with the default two-stage synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial bus clock |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data in |
| pwr_mode | output | 2 | Current power mode (00/01/10) |
| busy | output | 1 | High during the high-performance settling time |
| mode_changed | output | 1 | One-cycle pulse on every mode update |

## Verification
When chip select rises, two synchroniser flops, the edge-detect register and the frame register delay the command. The mode register then updates on the fourth system clock edge after the bench drives chip select high. For A3h, `busy` rises at that same edge, and the mode follows `HPM_CYCLES` edges later. The bench's reference model therefore schedules each decoded frame for the fourth clock after its chip-select release. The model counts the settling window itself, and the outputs are compared against the model on every falling clock edge, half a cycle after the design's registers update.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    localparam int BITCNT_W = 6;

    typedef enum logic [1:0] {
        PM_STBY  = 2'b00,
        PM_HPERF = 2'b01,
        PM_DPD   = 2'b10
    } pmode_e;

    localparam logic [7:0] OP_HIPERF  = 8'hA3;
    localparam logic [7:0] OP_RELEASE = 8'hAB;
    localparam logic [7:0] OP_PDOWN   = 8'hB9;

    localparam logic [BITCNT_W-1:0] OPC_BITS   = BITCNT_W'(8);
    localparam logic [BITCNT_W-1:0] HPERF_BITS = BITCNT_W'(32);

    typedef struct packed {
        logic                valid;
        logic [7:0]          opcode;
        logic [BITCNT_W-1:0] nbits;
    } frame_t;
endpackage

// File: rtl/fpc_sync.sv
module fpc_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] level
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign level = pipe_q[STAGES-1];
endmodule

// File: rtl/fpc_frame.sv
module fpc_frame
    import fpc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cs_n_lvl,
    input  logic   sclk_lvl,
    input  logic   si_lvl,
    output frame_t frame
);
    typedef struct packed {
        logic                cs_prev;
        logic                sclk_prev;
        logic [7:0]          shift;
        logic [7:0]          opcode;
        logic [BITCNT_W-1:0] nbits;
        logic                done;
    } fr_state_t;

    fr_state_t st_d, st_q;
    logic cs_rise, cs_fall, sclk_rise;

    assign cs_rise   =  cs_n_lvl & ~st_q.cs_prev;
    assign cs_fall   = ~cs_n_lvl &  st_q.cs_prev;
    assign sclk_rise =  sclk_lvl & ~st_q.sclk_prev;

    always_comb begin
        st_d           = st_q;
        st_d.cs_prev   = cs_n_lvl;
        st_d.sclk_prev = sclk_lvl;
        st_d.done      = cs_rise;
        if (cs_fall) begin
            st_d.shift  = '0;
            st_d.opcode = '0;
            st_d.nbits  = '0;
        end else if (!cs_n_lvl && sclk_rise) begin
            st_d.shift = {st_q.shift[6:0], si_lvl};
            if (st_q.nbits == OPC_BITS - BITCNT_W'(1)) begin
                st_d.opcode = {st_q.shift[6:0], si_lvl};
            end
            if (st_q.nbits != '1) begin
                st_d.nbits = st_q.nbits + BITCNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.cs_prev   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame.valid  = st_q.done;
    assign frame.opcode = st_q.opcode;
    assign frame.nbits  = st_q.nbits;
endmodule

// File: rtl/fpc_mode_fsm.sv
module fpc_mode_fsm
    import fpc_pkg::*;
#(
    parameter int HPM_CYCLES = 400,
    localparam int CNT_W     = $clog2(HPM_CYCLES + 1)
) (
    input  logic   clk,
    input  logic   rst_n,
    input  frame_t frame,
    output pmode_e mode,
    output logic   busy,
    output logic   mode_changed
);
    typedef struct packed {
        pmode_e           mode;
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             changed;
    } fsm_state_t;

    fsm_state_t st_d, st_q;
    logic cmd_ok;

    assign cmd_ok = frame.valid && (frame.nbits >= OPC_BITS);

    always_comb begin
        st_d         = st_q;
        st_d.changed = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy    = 1'b0;
                st_d.mode    = PM_HPERF;
                st_d.changed = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end else if (cmd_ok) begin
            unique case (st_q.mode)
                PM_STBY: begin
                    if (frame.opcode == OP_HIPERF && frame.nbits == HPERF_BITS) begin
                        st_d.busy = 1'b1;
                        st_d.cnt  = CNT_W'(HPM_CYCLES - 1);
                    end else if (frame.opcode == OP_PDOWN) begin
                        st_d.mode    = PM_DPD;
                        st_d.changed = 1'b1;
                    end
                end
                PM_HPERF: begin
                    if (frame.opcode == OP_RELEASE) begin
                        st_d.mode    = PM_STBY;
                        st_d.changed = 1'b1;
                    end else if (frame.opcode == OP_PDOWN) begin
                        st_d.mode    = PM_DPD;
                        st_d.changed = 1'b1;
                    end
                end
                PM_DPD: begin
                    if (frame.opcode == OP_RELEASE) begin
                        st_d.mode    = PM_STBY;
                        st_d.changed = 1'b1;
                    end
                end
                default: begin
                    st_d.mode    = PM_STBY;
                    st_d.changed = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= PM_STBY;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode         = st_q.mode;
    assign busy         = st_q.busy;
    assign mode_changed = st_q.changed;
endmodule

// File: rtl/flash_pwr_ctrl.sv
module flash_pwr_ctrl
    import fpc_pkg::*;
#(
    parameter int HPM_CYCLES  = 400,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sclk,
    input  logic       spi_cs_n,
    input  logic       spi_si,
    output logic [1:0] pwr_mode,
    output logic       busy,
    output logic       mode_changed
);
    logic [2:0] bus_lvl;
    frame_t     frame;
    pmode_e     mode;

    fpc_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_cs_n, spi_sclk, spi_si}),
        .level (bus_lvl)
    );

    fpc_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_lvl (bus_lvl[2]),
        .sclk_lvl (bus_lvl[1]),
        .si_lvl   (bus_lvl[0]),
        .frame    (frame)
    );

    fpc_mode_fsm #(
        .HPM_CYCLES (HPM_CYCLES)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame        (frame),
        .mode         (mode),
        .busy         (busy),
        .mode_changed (mode_changed)
    );

    assign pwr_mode = mode;
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
    parameter int HPM_CYCLES = 400
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] pwr_mode,
    input logic       busy,
    input logic       mode_changed
);
    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= 0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= 0;
    end

    // R1
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_mode != 2'b11);

    // R2
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_q < HPM_CYCLES);

    // R2
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q == HPM_CYCLES);

    // R2
    hperf_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_mode == 2'b01) |-> ($past(busy) && !busy));

    // R9
    busy_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> pwr_mode == 2'b00);

    // R7
    deep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_mode == 2'b10 |=> pwr_mode != 2'b01);

    // R10
    pulse_only_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_changed |-> pwr_mode != $past(pwr_mode));

    // R10
    change_has_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_mode != $past(pwr_mode) |-> mode_changed);
endmodule

bind flash_pwr_ctrl fpc_checker #(.HPM_CYCLES(HPM_CYCLES)) u_fpc_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_mode     (pwr_mode),
    .busy         (busy),
    .mode_changed (mode_changed)
);

// File: tb/flash_pwr_ctrl_test.sv
module flash_pwr_ctrl_test;
    localparam int HPM = 150;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_si = 1'b0;
    logic [1:0] pwr_mode;
    logic       busy;
    logic       mode_changed;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int pulses = 0;
    string cur_req = "R1";

    // reference model state
    int   m_mode = 0;
    bit   m_busy = 0;
    int   m_cnt = 0;
    bit   m_pulse = 0;
    int   sched = -1;
    int   s_opc = 0;
    int   s_bits = 0;

    always #4 clk = ~clk;

    flash_pwr_ctrl #(.HPM_CYCLES(HPM)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .spi_sclk     (spi_sclk),
        .spi_cs_n     (spi_cs_n),
        .spi_si       (spi_si),
        .pwr_mode     (pwr_mode),
        .busy         (busy),
        .mode_changed (mode_changed)
    );

    // behavioural model: command takes effect 4 edges after chip-select release (R11)
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            m_mode = 0; m_busy = 0; m_cnt = 0; m_pulse = 0;
        end else begin
            m_pulse = 0;
            if (m_busy) begin
                if (m_cnt == 0) begin
                    m_busy = 0; m_mode = 1; m_pulse = 1;
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end else if (cyc == sched && s_bits >= 8) begin
                if (m_mode == 0) begin
                    if (s_opc == 'hA3 && s_bits == 32) begin
                        m_busy = 1; m_cnt = HPM - 1;
                    end else if (s_opc == 'hB9) begin
                        m_mode = 2; m_pulse = 1;
                    end
                end else if (m_mode == 1) begin
                    if (s_opc == 'hAB) begin
                        m_mode = 0; m_pulse = 1;
                    end else if (s_opc == 'hB9) begin
                        m_mode = 2; m_pulse = 1;
                    end
                end else begin
                    if (s_opc == 'hAB) begin
                        m_mode = 0; m_pulse = 1;
                    end
                end
            end
        end
    end

    // per-cycle comparison, half a cycle after the update edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks = checks + 1;
            if (int'(pwr_mode) != m_mode || busy != m_busy || mode_changed != m_pulse) begin
                errors = errors + 1;
                $display("FAIL %s cycle %0d: mode/busy/pulse actual %0d/%0d/%0d expected %0d/%0d/%0d",
                         cur_req, cyc, pwr_mode, busy, mode_changed, m_mode, m_busy, m_pulse);
            end
            if (mode_changed) pulses = pulses + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] opc, input int nbits);
        @(negedge clk);
        spi_cs_n = 1'b0;
        idle(3);
        for (int i = 0; i < nbits; i++) begin
            spi_sclk = 1'b0;
            spi_si   = (i < 8) ? opc[7-i] : logic'(i % 2);
            idle(4);
            spi_sclk = 1'b1;
            idle(4);
        end
        spi_sclk = 1'b0;
        idle(3);
        spi_cs_n = 1'b1;
        s_opc  = int'(opc);
        s_bits = nbits;
        sched  = cyc + 4;
        idle(6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int p0;
        idle(5);
        check("R1 mode", int'(pwr_mode), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 pulse", int'(mode_changed), 0);
        rst_n = 1'b1;
        idle(5);

        cur_req = "R3";
        send_frame(8'hA3, 31); idle(10);
        check("R3 31 clocks", int'(pwr_mode) + int'(busy), 0);
        send_frame(8'hA3, 33); idle(10);
        check("R3 33 clocks", int'(pwr_mode) + int'(busy), 0);

        cur_req = "R8";
        send_frame(8'hB9, 5); idle(10);
        check("R8 short frame", int'(pwr_mode), 0);
        send_frame(8'h05, 16); idle(10);
        check("R8 other opcode", int'(pwr_mode), 0);

        cur_req = "R4";
        send_frame(8'hAB, 8); idle(10);
        check("R4 release in standby", int'(pwr_mode), 0);

        cur_req = "R2";
        p0 = pulses;
        send_frame(8'hA3, 32);
        check("R2 busy after entry", int'(busy), 1);
        cur_req = "R9";
        send_frame(8'hB9, 8);
        check("R9 mode while busy", int'(pwr_mode), 0);
        idle(HPM);
        cur_req = "R2";
        check("R2 mode after settling", int'(pwr_mode), 1);
        check("R2 busy cleared", int'(busy), 0);
        check("R10 single pulse", pulses - p0, 1);

        cur_req = "R3";
        send_frame(8'hA3, 32); idle(10);
        check("R3 entry in hi-perf", int'(pwr_mode) * 2 + int'(busy), 2);

        cur_req = "R4";
        send_frame(8'hAB, 24); idle(10);
        check("R4 release to standby", int'(pwr_mode), 0);

        cur_req = "R5";
        send_frame(8'hA3, 32); idle(HPM + 10);
        check("R5 hi-perf reached", int'(pwr_mode), 1);
        send_frame(8'hB9, 8); idle(10);
        check("R5 power-down", int'(pwr_mode), 2);

        cur_req = "R7";
        p0 = pulses;
        send_frame(8'hA3, 32); idle(10);
        send_frame(8'hB9, 8); idle(10);
        send_frame(8'h9F, 16); idle(10);
        check("R7 ignored in deep", int'(pwr_mode) * 2 + int'(busy), 4);
        check("R10 no pulse in deep", pulses - p0, 0);
        send_frame(8'hAB, 8); idle(10);
        check("R7 release from deep", int'(pwr_mode), 0);

        cur_req = "R6";
        send_frame(8'hB9, 8); idle(10);
        check("R6 power-down from standby", int'(pwr_mode), 2);
        cur_req = "R11";
        send_frame(8'hAB, 12); idle(10);
        check("R11 release with extra clocks", int'(pwr_mode), 0);

        idle(20);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule